// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

This block is a 16-bit timer channel with two ways of counting. In normal mode the counter only counts up. Its source is either one of three divided versions of the system clock or a selected edge of input A. In phase counting mode the counter counts up and down, driven by a quadrature pair on inputs A and B. It decodes every rising and falling edge of both inputs. In that mode the clock-source and edge selections have no effect. Counter clearing, the two general registers, the status flags and the interrupt enables all keep working in both modes.

Each of the two general registers works either as a compare register or as a capture register. A compare register matches against the counter. A capture register latches the counter on a rising edge of its own capture input. An overflow flag records wrap-around, and a flag-direction bit decides whether an underflow also sets it. Software reaches the channel through a plain synchronous register port: writes take effect on the clock edge, and the read data is combinational from the address. The block has no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain control and status pins. The interrupt output combines the flags with their enables.

Register map, with 3-bit addresses:
- 0: control.
  - bit 0: phase mode.
  - bits 2:1: clock source (0 = input A edge, 1 = clk/1, 2 = clk/4, 3 = clk/16).
  - bits 4:3: edge of A in normal mode (0 = rising, 1 = falling, 2 or 3 = both).
  - bits 6:5: clear source (1 = event A, 2 = event B, 0 or 3 = none).
  - bit 7: flag direction.
  - bit 8: capture mode for register A.
  - bit 9: capture mode for register B.
- 1: interrupt enable, with the same bit layout as the status register.
- 2: status. Bit 0 is the overflow flag, bit 1 is event A, bit 2 is event B.
- 3: counter.
- 4: general register A.
- 5: general register B.

Top module: `qtmr_channel`

## Requirements
- R1: After reset, these registers read as follows: counter 0, control 0, enables 0, status 0, general registers A and B 16'hFFFF. The interrupt output is low.
- R2: In normal mode with clock source 1, 2 or 3, the counter rises by exactly N, N/4 or N/16 over any N consecutive clocks, where N is a multiple of 16. Normal mode never counts down.
- R3: In normal mode with clock source 0, each selected edge of input A adds one: rising for edge code 0, falling for code 1, both for codes 2 and 3. Input B has no effect.
- R4: In phase mode the counter adds one in four cases: A rises while B is low, A falls while B is high, B rises while A is high, or B falls while A is low. The four opposite transitions subtract one. The counter changes by at most one per clock.
- R5: In phase mode, if A and B both change in the same synchronised sample, the counter is left unchanged.
- R6: In phase mode the clock-source and edge-select fields have no effect. With the inputs still, the counter does not move, whatever those fields are set to.
- R7: The counter wraps from 16'hFFFF up to 0, and that sets status bit 0. It also wraps from 0 down to 16'hFFFF. That underflow sets status bit 0 when the flag-direction bit is 0 and leaves it alone when the bit is 1.
- R8: Event A occurs when general register A is in compare mode and equals the counter. Event A sets status bit 1. With clear source 1, the counter becomes 0 on the next clock, whether it was counting up or down. Register B, status bit 2 and clear source 2 behave the same way.
- R9: A general register in capture mode loads the counter on a rising edge of its capture input. That edge sets the register's status bit. While the register is in capture mode, an equal counter value sets nothing.
- R10: A status bit clears only when 0 is written to it after a read of the status register, made while the bit was 1. Writing 0 without that read, or writing 1, leaves the bit as it is.
- R11: The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R12: A change on an input moves the counter at the third rising clock edge after the change. Both inputs pass through a two-stage synchroniser and a previous-sample register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qa_i | input | 1 | Count input A (quadrature phase A, or the external clock) |
| qb_i | input | 1 | Count input B (quadrature phase B) |
| cap_a_i | input | 1 | Capture trigger for general register A |
| cap_b_i | input | 1 | Capture trigger for general register B |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; reading the status register arms its bits for clearing |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks the full quadrature cycle forward and backward and checks the result after every single step. A decoder with a swapped term would count in the wrong direction on one edge, or drift. It changes both phases in the same cycle and expects no movement; a design that let such a transition through would gain or lose a count. It takes the counter through both wrap points with the flag-direction bit at 0 and at 1, and drives compare-clear in both counting directions. A wrong flag condition shows up as a spurious or missing overflow flag. A clear that only works upward shows up as a counter that passes the compare value. It also checks:
- that a status bit survives a write of 0 made without the arming read;
- the exact edge on which a synchronised input first moves the counter, so that a missing or extra flop shows up as an off-by-one count.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

  localparam int ADDR_W = 3;
  localparam int FLAG_N = 3;  // bit0 overflow, bit1 event A, bit2 event B
  localparam int GR_N   = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_IEN  = 3'd1,
    REG_STAT = 3'd2,
    REG_CNT  = 3'd3,
    REG_GRA  = 3'd4,
    REG_GRB  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    CK_EXT   = 2'd0,
    CK_DIV1  = 2'd1,
    CK_DIV4  = 2'd2,
    CK_DIV16 = 2'd3
  } clk_sel_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_A    = 2'd1,
    CLR_B    = 2'd2,
    CLR_OFF  = 2'd3
  } clr_sel_e;

  // packed: first member is the most significant
  typedef struct packed {
    logic [GR_N-1:0] cap_mode;  // [9:8]
    logic            flag_dir;  // [7]
    clr_sel_e        clr;       // [6:5]
    logic [1:0]      edge_sel;  // [4:3]
    clk_sel_e        clk_src;   // [2:1]
    logic            phase;     // [0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/qtmr_insync.sv
module qtmr_insync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] lvl,
  output logic [LANES-1:0] lvl_prev
);

  logic [LANES-1:0] stage_q [STAGES];
  logic [LANES-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];

  assign lvl      = stage_q[STAGES-1];
  assign lvl_prev = prev_q;

endmodule

// File: rtl/qtmr_stepgen.sv
module qtmr_stepgen
  import qtmr_pkg::*;
#(
  parameter int PRE_SHIFT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase,
  input  clk_sel_e   clk_src,
  input  logic [1:0] edge_sel,
  input  logic [1:0] lvl,       // [0] = A, [1] = B
  input  logic [1:0] lvl_prev,
  output logic       step_up,
  output logic       step_down
);

  localparam int PRE_W = 2 * PRE_SHIFT;
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [1:0] rise, fall;
  logic tick_mid, tick_slow, ext_hit, norm_tick, both_chg, q_up, q_dn;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_ONE;

  assign rise      = lvl & ~lvl_prev;
  assign fall      = ~lvl & lvl_prev;
  assign tick_mid  = &pre_q[PRE_SHIFT-1:0];
  assign tick_slow = &pre_q;
  assign both_chg  = (rise[0] | fall[0]) & (rise[1] | fall[1]);

  assign q_up = (rise[0] & ~lvl[1]) | (fall[0] & lvl[1]) |
                (rise[1] & lvl[0])  | (fall[1] & ~lvl[0]);
  assign q_dn = (rise[0] & lvl[1])  | (fall[0] & ~lvl[1]) |
                (rise[1] & ~lvl[0]) | (fall[1] & lvl[0]);

  always_comb begin
    unique case (edge_sel)
      2'd0:    ext_hit = rise[0];
      2'd1:    ext_hit = fall[0];
      default: ext_hit = rise[0] | fall[0];
    endcase
    unique case (clk_src)
      CK_EXT:   norm_tick = ext_hit;
      CK_DIV1:  norm_tick = 1'b1;
      CK_DIV4:  norm_tick = tick_mid;
      default:  norm_tick = tick_slow;
    endcase
    if (phase) begin
      step_up   = q_up & ~both_chg;
      step_down = q_dn & ~both_chg;
    end else begin
      step_up   = norm_tick;
      step_down = 1'b0;
    end
  end

  // R4: never both directions at once
  p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_down));

  // R2: normal mode only counts up
  p_norm_up_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> !step_down);

endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
  import qtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_SHIFT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qa_i,
  input  logic              qb_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  ctrl_t             ctrl_q;
  logic [FLAG_N-1:0] ien_q, stat_q, armed_q, flag_set, flag_clr;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  gr_q [GR_N];

  logic [1:0]      q_lvl, q_prev;
  logic [GR_N-1:0] c_lvl, c_prev, cap_rise, ev;
  logic step_up, step_down;
  logic wr_ctrl, wr_ien, wr_stat, wr_cnt, rd_stat, clr_now, ovf_hit;

  qtmr_insync #(.LANES(2), .STAGES(SYNC_STAGES)) u_qsync (
    .clk(clk), .rst_n(rst_n), .din({qb_i, qa_i}),
    .lvl(q_lvl), .lvl_prev(q_prev));

  qtmr_insync #(.LANES(GR_N), .STAGES(SYNC_STAGES)) u_csync (
    .clk(clk), .rst_n(rst_n), .din({cap_b_i, cap_a_i}),
    .lvl(c_lvl), .lvl_prev(c_prev));

  qtmr_stepgen #(.PRE_SHIFT(PRE_SHIFT)) u_step (
    .clk(clk), .rst_n(rst_n), .phase(ctrl_q.phase), .clk_src(ctrl_q.clk_src),
    .edge_sel(ctrl_q.edge_sel), .lvl(q_lvl), .lvl_prev(q_prev),
    .step_up(step_up), .step_down(step_down));

  assign cap_rise = c_lvl & ~c_prev;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == REG_CTRL);
  assign wr_ien  = reg_wr_i && (reg_addr_i == REG_IEN);
  assign wr_stat = reg_wr_i && (reg_addr_i == REG_STAT);
  assign wr_cnt  = reg_wr_i && (reg_addr_i == REG_CNT);
  assign rd_stat = reg_rd_i && (reg_addr_i == REG_STAT);

  // per general register: compare match or capture event
  generate
    for (genvar g = 0; g < GR_N; g++) begin : g_gr
      assign ev[g] = ctrl_q.cap_mode[g] ? cap_rise[g] : (cnt_q == gr_q[g]);
    end
  endgenerate

  assign clr_now = ((ctrl_q.clr == CLR_A) && ev[0]) ||
                   ((ctrl_q.clr == CLR_B) && ev[1]);

  assign ovf_hit = !wr_cnt && !clr_now &&
                   ((step_up && (cnt_q == '1)) ||
                    (step_down && (cnt_q == '0) && !ctrl_q.flag_dir));

  always_comb begin
    flag_set = {ev[1], ev[0], ovf_hit};
    for (int i = 0; i < FLAG_N; i++)
      flag_clr[i] = wr_stat && armed_q[i] && !reg_wdata_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
      armed_q <= '0;
      cnt_q   <= '0;
      for (int g = 0; g < GR_N; g++) gr_q[g] <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      if (wr_ien)  ien_q  <= reg_wdata_i[FLAG_N-1:0];
      stat_q  <= (stat_q & ~flag_clr) | flag_set;
      armed_q <= (rd_stat ? stat_q : armed_q) & ~flag_clr;
      if (wr_cnt)         cnt_q <= reg_wdata_i;
      else if (clr_now)   cnt_q <= '0;
      else if (step_up)   cnt_q <= cnt_q + CNT_ONE;
      else if (step_down) cnt_q <= cnt_q - CNT_ONE;
      for (int g = 0; g < GR_N; g++) begin
        if (reg_wr_i && (reg_addr_i == ADDR_W'(REG_GRA) + ADDR_W'(g)))
          gr_q[g] <= reg_wdata_i;
        else if (ctrl_q.cap_mode[g] && cap_rise[g])
          gr_q[g] <= cnt_q;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      REG_CTRL: reg_rdata_o = CNT_W'(ctrl_q);
      REG_IEN:  reg_rdata_o = CNT_W'(ien_q);
      REG_STAT: reg_rdata_o = CNT_W'(stat_q);
      REG_CNT:  reg_rdata_o = cnt_q;
      REG_GRA:  reg_rdata_o = gr_q[0];
      REG_GRB:  reg_rdata_o = gr_q[1];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & ien_q);

  // R4: without write or clear, the counter moves by at most one
  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !clr_now) |=> ((cnt_q == $past(cnt_q)) ||
                               (cnt_q == $past(cnt_q) + CNT_ONE) ||
                               (cnt_q == $past(cnt_q) - CNT_ONE)));

  // R5: simultaneous change of both phases leaves the counter alone
  p_invalid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.phase && (q_lvl[0] != q_prev[0]) && (q_lvl[1] != q_prev[1]) &&
     !wr_cnt && !clr_now) |=> $stable(cnt_q));

  // R8: selected event clears the counter on the next edge
  p_clear_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !wr_cnt) |=> (cnt_q == '0));

  // R7: flag direction 1 keeps underflow from raising the overflow flag
  p_underflow_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.flag_dir && step_down && !step_up && (cnt_q == '0) &&
     !stat_q[0] && !wr_cnt) |=> !stat_q[0]);

  // R10: a set flag persists unless an armed zero is written
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !(wr_stat && armed_q[0] && !reg_wdata_i[0])) |=> stat_q[0]);

endmodule

// File: tb/qtmr_channel_tb_top.sv
module qtmr_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qa = 1'b0, qb = 1'b0, cap_a = 1'b0, cap_b = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  qtmr_channel dut_i (
    .clk(clk), .rst_n(rst_n), .qa_i(qa), .qb_i(qb), .cap_a_i(cap_a),
    .cap_b_i(cap_b), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STAT = 3'd2,
                         A_CNT = 3'd3, A_GRA = 3'd4, A_GRB = 3'd5;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic clear_flags();
    @(negedge clk); addr = A_STAT; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    reg_write(A_STAT, 16'h0000);
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic step_fwd();
    @(negedge clk);
    case ({qa, qb})
      2'b00: qa = 1'b1;
      2'b10: qb = 1'b1;
      2'b11: qa = 1'b0;
      default: qb = 1'b0;
    endcase
    settle();
  endtask

  task automatic step_back();
    @(negedge clk);
    case ({qa, qb})
      2'b00: qb = 1'b1;
      2'b01: qa = 1'b1;
      2'b11: qb = 1'b0;
      default: qa = 1'b0;
    endcase
    settle();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(A_CNT, v);  chk("R1 cnt", v, 16'h0000);
    peek(A_CTRL, v); chk("R1 ctrl", v, 16'h0000);
    peek(A_IEN, v);  chk("R1 ien", v, 16'h0000);
    peek(A_STAT, v); chk("R1 stat", v, 16'h0000);
    peek(A_GRA, v);  chk("R1 gra", v, 16'hFFFF);
    peek(A_GRB, v);  chk("R1 grb", v, 16'hFFFF);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_latency_and_decode();
    logic [15:0] v;
    reg_write(A_CTRL, 16'h0001);
    @(negedge clk); qa = 1'b1;
    repeat (2) @(negedge clk);
    peek(A_CNT, v); chk("R12 before third edge", v, 16'h0000);
    @(negedge clk);
    peek(A_CNT, v); chk("R12 at third edge", v, 16'h0001);
    @(negedge clk);
    for (int i = 2; i <= 4; i++) begin
      step_fwd(); peek(A_CNT, v); chk("R4 forward", v, 16'(i));
    end
    for (int i = 3; i >= 0; i--) begin
      step_back(); peek(A_CNT, v); chk("R4 backward", v, 16'(i));
    end
  endtask

  task automatic t_invalid();
    logic [15:0] v;
    reg_write(A_CNT, 16'h0050);
    @(negedge clk); qa = 1'b1; qb = 1'b1; settle();
    peek(A_CNT, v); chk("R5 both rise", v, 16'h0050);
    @(negedge clk); qa = 1'b0; qb = 1'b0; settle();
    peek(A_CNT, v); chk("R5 both fall", v, 16'h0050);
  endtask

  task automatic t_phase_ignores();
    logic [15:0] v;
    reg_write(A_CTRL, 16'h0013);  // phase, clk/1, both edges
    repeat (20) @(negedge clk);
    peek(A_CNT, v); chk("R6 idle in phase mode", v, 16'h0050);
    step_fwd(); peek(A_CNT, v); chk("R6 still decodes", v, 16'h0051);
    step_back();
  endtask

  task automatic run_div(input logic [15:0] ctl, input int cyc, input int exp, input string req);
    logic [15:0] v;
    reg_write(A_CTRL, 16'h0001);
    reg_write(A_CNT, 16'h0000);
    reg_write(A_CTRL, ctl);
    repeat (cyc) @(negedge clk);
    peek(A_CNT, v); chk(req, v, 16'(exp));
  endtask

  task automatic t_prescale();
    run_div(16'h0002, 32, 32, "R2 clk/1");
    run_div(16'h0004, 48, 12, "R2 clk/4");
    run_div(16'h0006, 64, 4,  "R2 clk/16");
    reg_write(A_CTRL, 16'h0001);
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); qa = 1'b1; settle();
      @(negedge clk); qa = 1'b0; settle();
    end
  endtask

  task automatic t_ext();
    logic [15:0] v;
    reg_write(A_CNT, 16'h0000);
    reg_write(A_CTRL, 16'h0000);  // ext, rising
    pulse_a(3);
    peek(A_CNT, v); chk("R3 rising", v, 16'd3);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); qb = 1'b1; settle();
      @(negedge clk); qb = 1'b0; settle();
    end
    peek(A_CNT, v); chk("R3 B ignored", v, 16'd3);
    reg_write(A_CTRL, 16'h0008);  // falling
    pulse_a(3);
    peek(A_CNT, v); chk("R3 falling", v, 16'd6);
    reg_write(A_CTRL, 16'h0010);  // both
    pulse_a(3);
    peek(A_CNT, v); chk("R3 both edges", v, 16'd12);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    reg_write(A_CTRL, 16'h0001);
    reg_write(A_CNT, 16'hFFFF);
    clear_flags();
    step_fwd();
    peek(A_CNT, v);  chk("R7 up wrap", v, 16'h0000);
    peek(A_STAT, v); chk("R7 overflow flag", v & 16'h1, 16'h1);
    clear_flags();
    step_back();
    peek(A_CNT, v);  chk("R7 down wrap", v, 16'hFFFF);
    peek(A_STAT, v); chk("R7 underflow flag dir0", v & 16'h1, 16'h1);
    reg_write(A_CTRL, 16'h0081);
    reg_write(A_CNT, 16'h0000);
    clear_flags();
    step_back();
    peek(A_CNT, v);  chk("R7 down wrap dir1", v, 16'hFFFF);
    peek(A_STAT, v); chk("R7 no flag on underflow dir1", v & 16'h1, 16'h0);
    step_fwd();
    peek(A_STAT, v); chk("R7 overflow flag dir1", v & 16'h1, 16'h1);
  endtask

  task automatic t_flag_irq();
    logic [15:0] v;
    reg_write(A_IEN, 16'h0001);
    #1 chk("R11 irq on", {15'd0, irq}, 16'h0001);
    reg_write(A_STAT, 16'h0000);  // no arming read
    peek(A_STAT, v); chk("R10 unarmed write", v & 16'h1, 16'h1);
    reg_write(A_IEN, 16'h0000);
    #1 chk("R11 irq masked", {15'd0, irq}, 16'h0000);
    reg_write(A_IEN, 16'h0001);
    clear_flags();
    peek(A_STAT, v); chk("R10 armed clear", v & 16'h1, 16'h0);
    chk("R11 irq off", {15'd0, irq}, 16'h0000);
    reg_write(A_STAT, 16'h0007);
    peek(A_STAT, v); chk("R10 write one no set", v & 16'h1, 16'h0);
    reg_write(A_IEN, 16'h0000);
  endtask

  task automatic t_compare();
    logic [15:0] v;
    reg_write(A_CTRL, 16'h0021);  // phase, clear on A
    reg_write(A_GRA, 16'h0003);
    reg_write(A_CNT, 16'h0000);
    clear_flags();
    step_fwd(); step_fwd(); step_fwd();
    peek(A_CNT, v);  chk("R8 clear counting up", v, 16'h0000);
    peek(A_STAT, v); chk("R8 flag A", v & 16'h2, 16'h2);
    reg_write(A_CNT, 16'h0005);
    step_back(); step_back();
    peek(A_CNT, v);  chk("R8 clear counting down", v, 16'h0000);
    reg_write(A_CTRL, 16'h0041);  // clear on B
    reg_write(A_GRB, 16'h0002);
    reg_write(A_CNT, 16'h0000);
    clear_flags();
    step_fwd(); step_fwd();
    peek(A_CNT, v);  chk("R8 clear on B", v, 16'h0000);
    peek(A_STAT, v); chk("R8 flag B", v & 16'h4, 16'h4);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    reg_write(A_CTRL, 16'h0201);  // phase, B capture
    reg_write(A_CNT, 16'h1234);
    clear_flags();
    @(negedge clk); cap_b = 1'b1; settle();
    peek(A_GRB, v);  chk("R9 captured value", v, 16'h1234);
    peek(A_STAT, v); chk("R9 capture flag", v & 16'h4, 16'h4);
    clear_flags();
    repeat (4) @(negedge clk);
    peek(A_STAT, v); chk("R9 no compare in capture mode", v & 16'h4, 16'h0);
    @(negedge clk); cap_b = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency_and_decode();
    t_invalid();
    t_phase_ignores();
    t_prescale();
    t_ext();
    t_wrap();
    t_flag_irq();
    t_compare();
    t_capture();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule